// File: doc/BRIEF.md
# Hardware Standby Entry Controller

This block sequences a small processor subsystem into and out of hardware standby, the deepest low-power state. It watches an active-low standby request pin, an active-low power-on reset pin and the mode reported by the clock generator (run, sleep, software standby, watchdog settling after an interrupt wake). From these it drives the module clock enable, the oscillator enable, the timer halt, the gating of interrupts and manual reset, and the timer clock output. Only logic in the real-time-clock domain keeps running while the block holds hardware standby.

Where standby is entered depends on the present low-power mode. From run or software standby the block goes straight into hardware standby. From sleep, or while the watchdog is timing an interrupt wake from software standby, the request is held pending until the CPU is running again. Hardware standby can only be left through power-on reset. With reset held low, raising the standby pin restarts the oscillator and a settle counter runs. Releasing reset then starts CPU reset processing. A release that comes before the counter expires is flagged.

States: RUN, SLEEP, SWSTBY (software standby or watchdog settling), PEND (request pending), HWSTBY, SETTLE (oscillator settling), PORST (power-on reset processing). Transitions: mirror (RUN/SLEEP/SWSTBY follow the clock-generator mode), direct entry (RUN/SWSTBY to HWSTBY), deferred entry (SLEEP/SWSTBY to PEND, then PEND to HWSTBY), wake (HWSTBY to SETTLE), re-entry (SETTLE to HWSTBY), release (SETTLE to PORST), reset hold (RUN/SLEEP/SWSTBY/PEND to PORST), and resume (PORST to RUN).

Top module: `hw_standby_ctrl`

## Requirements
- R1: After reset, state_code is 0 (RUN), clk_en, osc_en, clk_stable and mrst_out_n are 1, and timer_halt, irq_out, tclk_out, cpu_rst and early_rel_err are 0.
- R2: With stby_req_n and por_n high, state_code follows cpg_mode one cycle later: mode 0 gives 0 (RUN), mode 1 gives 1 (SLEEP), modes 2 and 3 give 2 (SWSTBY); clk_en is 1 in RUN and SLEEP and 0 in SWSTBY.
- R3: stby_req_n sampled low with por_n high while cpg_mode is 0 or 2 and the state is RUN, SLEEP or SWSTBY moves the state to 4 (HWSTBY) at the next edge.
- R4: stby_req_n sampled low with cpg_mode 1 or 3 moves the state to 3 (PEND). PEND ignores stby_req_n and stays until cpg_mode is 0, then moves to HWSTBY at the next edge.
- R5: In HWSTBY and SETTLE (code 5), irq_out is 0, mrst_out_n is 1, tclk_out is 0, timer_halt is 1 and clk_en is 0. In the other states irq_out, mrst_out_n and tclk_out copy irq_in, mrst_in_n and tclk_in with one cycle of delay.
- R6: HWSTBY is left only when stby_req_n is high and por_n is low at the same edge. With por_n high it stays in HWSTBY whatever stby_req_n does. osc_en and clk_stable are 0 in HWSTBY.
- R7: After the edge that enters SETTLE, clk_stable is 0 and rises exactly SETTLE_CYCLES edges later. osc_en is 1 in SETTLE.
- R8: por_n sampled high in SETTLE gives state 6 (PORST) with cpu_rst 1 for one cycle, then RUN.
- R9: por_n sampled high in SETTLE while clk_stable is still 0 sets early_rel_err. The flag stays set until the next entry into SETTLE clears it. A release after clk_stable is 1 leaves it clear.
- R10: por_n sampled low in RUN, SLEEP, SWSTBY or PEND gives PORST with cpu_rst 1. The block stays there while por_n is low and returns to RUN one edge after por_n is high.
- R11: stby_req_n sampled low again in SETTLE while por_n is low returns the state to HWSTBY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous register reset, active low |
| stby_req_n | input | 1 | Hardware standby request, active low |
| por_n | input | 1 | Power-on reset pin, active low |
| cpg_mode | input | 2 | Clock-generator mode: 0 run, 1 sleep, 2 software standby, 3 watchdog settling |
| irq_in | input | 1 | Interrupt request to be gated |
| mrst_in_n | input | 1 | Manual reset request to be gated, active low |
| tclk_in | input | 1 | Timer clock to be gated |
| state_code | output | 3 | Current state code (0..6) |
| clk_en | output | 1 | Module clock enable |
| osc_en | output | 1 | Oscillator enable |
| clk_stable | output | 1 | Clock reported stable |
| timer_halt | output | 1 | Timer unit halt |
| irq_out | output | 1 | Gated interrupt request |
| mrst_out_n | output | 1 | Gated manual reset, active low |
| tclk_out | output | 1 | Gated timer clock output |
| cpu_rst | output | 1 | CPU power-on reset processing in progress |
| early_rel_err | output | 1 | Sticky flag: reset released before settling completed |

## Verification
A wrong state shows on state_code at the very next edge, because every transition is made in one cycle from the sampled pins. A stuck or misloaded settle counter shows on clk_stable at the wrong edge inside the SETTLE window, and on early_rel_err when the release time is swept across the window boundary. A wrong gating decode shows on irq_out, mrst_out_n and tclk_out one cycle after the inputs are driven high.

// File: rtl/hwsb_pkg.sv
package hwsb_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_SWSTBY = 3'd2,
        ST_PEND   = 3'd3,
        ST_HWSTBY = 3'd4,
        ST_SETTLE = 3'd5,
        ST_PORST  = 3'd6
    } pm_state_e;

    typedef enum logic [1:0] {
        CPG_RUN    = 2'd0,
        CPG_SLEEP  = 2'd1,
        CPG_SWSTBY = 2'd2,
        CPG_WDT    = 2'd3
    } cpg_mode_e;
endpackage

// File: rtl/hwsb_next_state.sv
module hwsb_next_state
    import hwsb_pkg::*;
(
    input  pm_state_e state_q,
    input  logic [1:0] cpg_mode,
    input  logic      stby_req_n,
    input  logic      por_n,
    input  logic      settled,
    output pm_state_e state_nxt,
    output logic      early_rel
);
    cpg_mode_e mode;
    pm_state_e mirror;

    assign mode = cpg_mode_e'(cpg_mode);

    always_comb begin
        unique case (mode)
            CPG_RUN:   mirror = ST_RUN;
            CPG_SLEEP: mirror = ST_SLEEP;
            default:   mirror = ST_SWSTBY;
        endcase
    end

    always_comb begin
        state_nxt = state_q;
        early_rel = 1'b0;
        unique case (state_q)
            ST_RUN, ST_SLEEP, ST_SWSTBY: begin
                if (!por_n)
                    state_nxt = ST_PORST;
                else if (!stby_req_n)
                    state_nxt = (mode == CPG_RUN || mode == CPG_SWSTBY) ? ST_HWSTBY : ST_PEND;
                else
                    state_nxt = mirror;
            end
            ST_PEND: begin
                if (!por_n)
                    state_nxt = ST_PORST;
                else if (mode == CPG_RUN)
                    state_nxt = ST_HWSTBY;
            end
            ST_HWSTBY: begin
                if (!por_n && stby_req_n)
                    state_nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (por_n) begin
                    state_nxt = ST_PORST;
                    early_rel = !settled;
                end else if (!stby_req_n) begin
                    state_nxt = ST_HWSTBY;
                end
            end
            ST_PORST: begin
                if (por_n)
                    state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end
endmodule

// File: rtl/hwsb_settle_ctr.sv
module hwsb_settle_ctr
    import hwsb_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_e state_q,
    input  pm_state_e state_nxt,
    output logic      settled,
    output logic      settled_nxt
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt_q;
        if (state_nxt == ST_SETTLE && state_q != ST_SETTLE)
            cnt_nxt = '0;
        else if (state_q == ST_SETTLE && cnt_q != LIMIT)
            cnt_nxt = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

    assign settled     = (cnt_q == LIMIT);
    assign settled_nxt = (cnt_nxt == LIMIT);
endmodule

// File: rtl/hwsb_out_regs.sv
module hwsb_out_regs
    import hwsb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_e state_q,
    input  pm_state_e state_nxt,
    input  logic      settled_nxt,
    input  logic      early_rel,
    input  logic      irq_in,
    input  logic      mrst_in_n,
    input  logic      tclk_in,
    output logic      clk_en,
    output logic      osc_en,
    output logic      clk_stable,
    output logic      timer_halt,
    output logic      irq_out,
    output logic      mrst_out_n,
    output logic      tclk_out,
    output logic      cpu_rst,
    output logic      early_rel_err
);
    logic frozen;
    logic run_clk;
    logic stable_d;
    logic settle_entry;

    assign frozen       = (state_nxt == ST_HWSTBY) || (state_nxt == ST_SETTLE);
    assign run_clk      = (state_nxt == ST_RUN) || (state_nxt == ST_SLEEP) ||
                          (state_nxt == ST_PEND) || (state_nxt == ST_PORST);
    assign settle_entry = (state_nxt == ST_SETTLE) && (state_q != ST_SETTLE);

    always_comb begin
        unique case (state_nxt)
            ST_SETTLE: stable_d = settled_nxt;
            ST_HWSTBY: stable_d = 1'b0;
            default:   stable_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_en        <= 1'b1;
            osc_en        <= 1'b1;
            clk_stable    <= 1'b1;
            timer_halt    <= 1'b0;
            irq_out       <= 1'b0;
            mrst_out_n    <= 1'b1;
            tclk_out      <= 1'b0;
            cpu_rst       <= 1'b0;
            early_rel_err <= 1'b0;
        end else begin
            clk_en     <= run_clk;
            osc_en     <= (state_nxt != ST_HWSTBY);
            clk_stable <= stable_d;
            timer_halt <= frozen;
            irq_out    <= irq_in & ~frozen;
            mrst_out_n <= mrst_in_n | frozen;
            tclk_out   <= tclk_in & ~frozen;
            cpu_rst    <= (state_nxt == ST_PORST);
            if (settle_entry)
                early_rel_err <= 1'b0;
            else if (early_rel)
                early_rel_err <= 1'b1;
        end
    end
endmodule

// File: rtl/hw_standby_ctrl.sv
module hw_standby_ctrl
    import hwsb_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_req_n,
    input  logic       por_n,
    input  logic [1:0] cpg_mode,
    input  logic       irq_in,
    input  logic       mrst_in_n,
    input  logic       tclk_in,
    output logic [2:0] state_code,
    output logic       clk_en,
    output logic       osc_en,
    output logic       clk_stable,
    output logic       timer_halt,
    output logic       irq_out,
    output logic       mrst_out_n,
    output logic       tclk_out,
    output logic       cpu_rst,
    output logic       early_rel_err
);
    pm_state_e state_q;
    pm_state_e state_nxt;
    logic      settled;
    logic      settled_nxt;
    logic      early_rel;

    hwsb_next_state u_nxt (
        .state_q    (state_q),
        .cpg_mode   (cpg_mode),
        .stby_req_n (stby_req_n),
        .por_n      (por_n),
        .settled    (settled),
        .state_nxt  (state_nxt),
        .early_rel  (early_rel)
    );

    hwsb_settle_ctr #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_q     (state_q),
        .state_nxt   (state_nxt),
        .settled     (settled),
        .settled_nxt (settled_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_nxt;
    end

    hwsb_out_regs u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_q       (state_q),
        .state_nxt     (state_nxt),
        .settled_nxt   (settled_nxt),
        .early_rel     (early_rel),
        .irq_in        (irq_in),
        .mrst_in_n     (mrst_in_n),
        .tclk_in       (tclk_in),
        .clk_en        (clk_en),
        .osc_en        (osc_en),
        .clk_stable    (clk_stable),
        .timer_halt    (timer_halt),
        .irq_out       (irq_out),
        .mrst_out_n    (mrst_out_n),
        .tclk_out      (tclk_out),
        .cpu_rst       (cpu_rst),
        .early_rel_err (early_rel_err)
    );

    assign state_code = state_q;
endmodule

// File: rtl/hwsb_checker.sv
module hwsb_checker
    import hwsb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       stby_req_n,
    input logic       por_n,
    input logic [1:0] cpg_mode,
    input logic [2:0] state_code,
    input logic       clk_stable,
    input logic       osc_en,
    input logic       irq_out,
    input logic       tclk_out,
    input logic       cpu_rst,
    input logic       early_rel_err
);
    logic normal_st;
    assign normal_st = (state_code == ST_RUN) || (state_code == ST_SLEEP) ||
                       (state_code == ST_SWSTBY) || (state_code == ST_PEND);

    // R2
    mirror_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_RUN && stby_req_n && por_n && cpg_mode == CPG_SLEEP) |=> state_code == ST_SLEEP);

    // R3
    direct_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_RUN && !stby_req_n && por_n && cpg_mode == CPG_RUN) |=> state_code == ST_HWSTBY);

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_PEND && por_n && cpg_mode != CPG_RUN) |=> state_code == ST_PEND);

    // R5
    irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_HWSTBY || state_code == ST_SETTLE) |-> (!irq_out && !tclk_out));

    // R6
    hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_HWSTBY && por_n) |=> state_code == ST_HWSTBY);

    // R6
    hw_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_HWSTBY) |-> (!osc_en && !clk_stable));

    // R8
    porst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_SETTLE && por_n) |=> (state_code == ST_PORST && cpu_rst));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (early_rel_err && state_code != ST_HWSTBY) |=> early_rel_err);

    // R10
    por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_st && !por_n) |=> state_code == ST_PORST);

    // R11
    reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_SETTLE && !por_n && !stby_req_n) |=> state_code == ST_HWSTBY);
endmodule

bind hw_standby_ctrl hwsb_checker u_hwsb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .stby_req_n    (stby_req_n),
    .por_n         (por_n),
    .cpg_mode      (cpg_mode),
    .state_code    (state_code),
    .clk_stable    (clk_stable),
    .osc_en        (osc_en),
    .irq_out       (irq_out),
    .tclk_out      (tclk_out),
    .cpu_rst       (cpu_rst),
    .early_rel_err (early_rel_err)
);

// File: tb/test_hw_standby_ctrl.sv
module test_hw_standby_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stby_req_n = 1'b1;
    logic       por_n = 1'b1;
    logic [1:0] cpg_mode = 2'd0;
    logic       irq_in = 1'b0;
    logic       mrst_in_n = 1'b1;
    logic       tclk_in = 1'b0;
    logic [2:0] state_code;
    logic       clk_en, osc_en, clk_stable, timer_halt;
    logic       irq_out, mrst_out_n, tclk_out, cpu_rst, early_rel_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hw_standby_ctrl #(.SETTLE_CYCLES(SETTLE)) i_hw_standby_ctrl (
        .clk(clk), .rst_n(rst_n), .stby_req_n(stby_req_n), .por_n(por_n),
        .cpg_mode(cpg_mode), .irq_in(irq_in), .mrst_in_n(mrst_in_n), .tclk_in(tclk_in),
        .state_code(state_code), .clk_en(clk_en), .osc_en(osc_en), .clk_stable(clk_stable),
        .timer_halt(timer_halt), .irq_out(irq_out), .mrst_out_n(mrst_out_n),
        .tclk_out(tclk_out), .cpu_rst(cpu_rst), .early_rel_err(early_rel_err)
    );

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // From HWSTBY: wake, wait j edges in SETTLE, release reset, return to RUN
    task automatic wake(input int j);
        stby_req_n = 1'b1;
        por_n      = 1'b0;
        tick();
        chk(state_code, 5, "R7 enter SETTLE");
        chk(osc_en, 1, "R7 osc_en in SETTLE");
        chk(early_rel_err, 0, "R9 cleared on SETTLE entry");
        chk(clk_stable, (SETTLE <= 0) ? 1 : 0, "R7 clk_stable at entry");
        for (int i = 1; i <= j; i++) begin
            tick();
            chk(clk_stable, (i >= SETTLE) ? 1 : 0, "R7 clk_stable window");
        end
        por_n = 1'b1;
        tick();
        chk(state_code, 6, "R8 PORST after release");
        chk(cpu_rst, 1, "R8 cpu_rst");
        chk(early_rel_err, (j < SETTLE) ? 1 : 0, "R9 early release flag");
        tick();
        chk(state_code, 0, "R8 back to RUN");
        chk(cpu_rst, 0, "R8 cpu_rst drops");
        chk(early_rel_err, (j < SETTLE) ? 1 : 0, "R9 flag sticky in RUN");
    endtask

    task automatic enter_hw();
        cpg_mode   = 2'd0;
        stby_req_n = 1'b0;
        por_n      = 1'b1;
        tick();
        chk(state_code, 4, "R3 direct entry from RUN");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick();
        tick();
        // R1 reset state
        chk(state_code, 0, "R1 state");
        chk(clk_en, 1, "R1 clk_en");
        chk(osc_en, 1, "R1 osc_en");
        chk(clk_stable, 1, "R1 clk_stable");
        chk(mrst_out_n, 1, "R1 mrst_out_n");
        chk(timer_halt, 0, "R1 timer_halt");
        chk(irq_out, 0, "R1 irq_out");
        chk(tclk_out, 0, "R1 tclk_out");
        chk(cpu_rst, 0, "R1 cpu_rst");
        chk(early_rel_err, 0, "R1 early_rel_err");
        rst_n = 1'b1;
        tick();

        // R2 mirror sweep, both directions
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 4; k++) begin
                int c = (r == 0) ? k : 3 - k;
                cpg_mode = 2'(c);
                tick();
                chk(state_code, (c == 0) ? 0 : (c == 1) ? 1 : 2, "R2 mirror state");
                chk(clk_en, (c < 2) ? 1 : 0, "R2 clk_en");
            end
        end

        // R5 pass-through in RUN
        cpg_mode = 2'd0;
        irq_in = 1'b1; mrst_in_n = 1'b0; tclk_in = 1'b1;
        tick();
        chk(irq_out, 1, "R5 irq pass in RUN");
        chk(mrst_out_n, 0, "R5 mrst pass in RUN");
        chk(tclk_out, 1, "R5 tclk pass in RUN");
        chk(timer_halt, 0, "R5 timer runs in RUN");

        // R3/R4 entry sweep over every clock-generator mode
        for (int c = 0; c < 4; c++) begin
            stby_req_n = 1'b1; por_n = 1'b1; cpg_mode = 2'(c);
            tick();
            stby_req_n = 1'b0;
            tick();
            if (c == 0 || c == 2) begin
                chk(state_code, 4, "R3 direct entry");
            end else begin
                chk(state_code, 3, "R4 deferred entry");
                chk(irq_out, 1, "R5 irq pass in PEND");
                stby_req_n = 1'b1;
                tick();
                chk(state_code, 3, "R4 PEND ignores stby_req_n");
                tick();
                chk(state_code, 3, "R4 PEND holds");
                cpg_mode = 2'd0;
                tick();
                chk(state_code, 4, "R4 PEND to HWSTBY on resume");
            end
            // R5 gating in HWSTBY with all inputs active
            chk(irq_out, 0, "R5 irq blocked");
            chk(mrst_out_n, 1, "R5 mrst blocked");
            chk(tclk_out, 0, "R5 tclk low");
            chk(timer_halt, 1, "R5 timer halted");
            chk(clk_en, 0, "R5 clk_en off");
            chk(osc_en, 0, "R6 osc_en off");
            chk(clk_stable, 0, "R6 clk_stable off");
            // R6 standby pin high with reset high is ignored
            stby_req_n = 1'b1; por_n = 1'b1;
            tick();
            chk(state_code, 4, "R6 stays without reset");
            stby_req_n = 1'b0; por_n = 1'b0;
            tick();
            chk(state_code, 4, "R6 reset alone does not wake");
            wake(SETTLE);
        end

        // R9/R7 release-time sweep across the settle window
        for (int j = 0; j <= SETTLE + 2; j++) begin
            enter_hw();
            wake(j);
        end

        // R11 re-entry from SETTLE
        enter_hw();
        stby_req_n = 1'b1; por_n = 1'b0;
        tick();
        chk(state_code, 5, "R11 in SETTLE");
        stby_req_n = 1'b0;
        tick();
        chk(state_code, 4, "R11 back to HWSTBY");
        chk(tclk_out, 0, "R5 tclk low after re-entry");
        wake(SETTLE + 1);

        // R10 power-on reset from normal states
        for (int c = 0; c < 3; c++) begin
            stby_req_n = 1'b1; por_n = 1'b1; cpg_mode = 2'(c);
            tick();
            por_n = 1'b0;
            tick();
            chk(state_code, 6, "R10 PORST entry");
            chk(cpu_rst, 1, "R10 cpu_rst");
            tick();
            chk(state_code, 6, "R10 PORST held");
            por_n = 1'b1; cpg_mode = 2'd0;
            tick();
            chk(state_code, 0, "R10 back to RUN");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule